// File: doc/BRIEF.md
# Self-Triggered Hit Time and Amplitude Capture Channel

This block is the digital part of one channel in a self-triggered, many-channel detector front end. A coarse time counter runs freely on the timing clock. When the channel's discriminator fires, the trigger is brought into the clock domain and its rising edge is detected. The current counter value is then held while the channel waits for the amplitude that a peak detector delivers some cycles later.

When the amplitude strobe arrives, the time and amplitude are written as one entry into a four-deep derandomising FIFO. A readout multiplexer scans the channels. It sees a registered not-empty flag and a registered head entry, which carries the fixed channel number as the spatial coordinate, and it pops the entry once it has taken it.

Hits that cannot be handled are not silently lost:
- A retrigger while an amplitude is still awaited is counted as dead time.
- An entry that finds the FIFO full is dropped and raises a sticky overflow flag.
- A hit whose amplitude never comes is abandoned after a fixed window.

Top module: `hit_capture_channel`

## Requirements
- R1: `time_now` is 0 in the cycle after a reset edge and rises by one on every later clock edge. It is 14 bits wide and wraps from 16383 to 0.
- R2: `trig_in` passes through two synchronising flops, and each 0-to-1 transition arms at most one hit. The hit's time stamp equals the `time_now` value seen in the cycle that follows the second rising clock edge at which `trig_in` is sampled high.
- R3: While a hit is armed, `amp_valid` sampled high at any of the 64 clock edges after arming completes the hit. An entry made of the held time stamp and `amp_data` is written into the FIFO at that same edge.
- R4: If no `amp_valid` is sampled in those 64 edges, the armed hit is discarded and no entry is written.
- R5: A trigger rising edge detected while a hit is armed does not re-arm and does not change the held time stamp. It increments `dead_count`, which saturates at all ones.
- R6: `amp_valid` sampled while no hit is armed has no effect.
- R7: The FIFO holds 4 entries and delivers them in write order. `not_empty`, `head_time` and `head_amp` are registers that reflect the FIFO state after each edge, so a write into an empty FIFO is visible in the next cycle.
- R8: `pop` sampled high while `not_empty` is 1 removes the head entry. `pop` while empty has no effect.
- R9: A write that finds all 4 slots occupied at its edge is dropped, even when `pop` is high at the same edge. The drop sets `overflow`, which then stays 1.
- R10: `ovf_clear` sampled high clears `overflow` at that edge, unless a drop occurs at the same edge.
- R11: `head_chan` always equals the channel-number parameter `CHAN_ID`.
- R12: A synchronous reset empties the FIFO, clears `overflow` and `dead_count`, and abandons any armed hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | Asynchronous discriminator output |
| amp_valid | input | 1 | Amplitude strobe from the peak-detector digitiser |
| amp_data | input | AMP_W | Amplitude value |
| pop | input | 1 | Readout removes the head entry |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| time_now | output | TS_W | Free-running coarse time |
| not_empty | output | 1 | FIFO holds at least one entry |
| head_time | output | TS_W | Time stamp of the head entry |
| head_amp | output | AMP_W | Amplitude of the head entry |
| head_chan | output | CH_W | Channel number (spatial coordinate) |
| overflow | output | 1 | Sticky: a hit was lost to a full FIFO |
| dead_count | output | DC_W | Saturating count of ignored retriggers |

## Verification
A wrong pending state shows up in one of three ways. It can produce an entry with the wrong time stamp at the head one cycle after the amplitude strobe. It can produce a missing entry, which leaves `not_empty` low. Or it can bump `dead_count` in the cycle after a retrigger. A corrupted FIFO pointer or count shows up at the next write or pop, as a head entry that is out of order or a `not_empty` that is wrong. The bench compares every output against its behavioural model on every cycle, so any divergence is reported within one cycle of the edge that caused it.

// File: rtl/hcap_pkg.sv
package hcap_pkg;
  typedef enum logic {PS_IDLE, PS_ARMED} pair_state_e;
endpackage

// File: rtl/hcap_timer.sv
module hcap_timer #(
  parameter int TS_W = 14
) (
  input  logic            clk,
  input  logic            rst,
  output logic [TS_W-1:0] time_o
);
  always_ff @(posedge clk) begin
    if (rst) time_o <= '0;
    else     time_o <= time_o + TS_W'(1);
  end
endmodule

// File: rtl/hcap_trig_sync.sv
module hcap_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic trig_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], trig_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/hcap_pair.sv
module hcap_pair
  import hcap_pkg::*;
#(
  parameter int TS_W  = 14,
  parameter int AMP_W = 8,
  parameter int TMO   = 64,
  parameter int DC_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rise_i,
  input  logic [TS_W-1:0]  time_i,
  input  logic             amp_valid_i,
  input  logic [AMP_W-1:0] amp_i,
  output logic             push_o,
  output logic [TS_W-1:0]  push_ts_o,
  output logic [AMP_W-1:0] push_amp_o,
  output logic [DC_W-1:0]  dead_o
);
  localparam int WW = (TMO > 1) ? $clog2(TMO) : 1;
  localparam logic [WW-1:0] WLAST = WW'(TMO - 1);

  pair_state_e       st_q;
  logic [TS_W-1:0]   ts_q;
  logic [WW-1:0]     wait_q;

  assign push_o     = (st_q == PS_ARMED) && amp_valid_i;
  assign push_ts_o  = ts_q;
  assign push_amp_o = amp_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PS_IDLE;
      ts_q   <= '0;
      wait_q <= '0;
      dead_o <= '0;
    end else if (st_q == PS_ARMED) begin
      if (amp_valid_i)          st_q <= PS_IDLE;
      else if (wait_q == WLAST) st_q <= PS_IDLE;
      else                      wait_q <= wait_q + WW'(1);
      if (rise_i && (dead_o != '1)) dead_o <= dead_o + DC_W'(1);
    end else if (rise_i) begin
      st_q   <= PS_ARMED;
      ts_q   <= time_i;
      wait_q <= '0;
    end
  end
endmodule

// File: rtl/hcap_fifo.sv
module hcap_fifo #(
  parameter int W     = 22,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         pop_i,
  input  logic         ovf_clr_i,
  output logic         not_empty_o,
  output logic [W-1:0] head_o,
  output logic         drop_o,
  output logic         ovf_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_q, wr_q, nxt_rd;
  logic [CW-1:0] cnt_q;
  logic          full, wr_ok, pop_ok;

  assign full   = (cnt_q == CW'(DEPTH));
  assign wr_ok  = wr_i && !full;
  assign drop_o = wr_i && full;
  assign pop_ok = pop_i && (cnt_q != '0);
  assign nxt_rd = rd_q + AW'(pop_ok);

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wr_q] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (wr_ok && (wr_q == nxt_rd)) head_o <= wr_data_i;
    else                           head_o <= mem[nxt_rd];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q        <= '0;
      wr_q        <= '0;
      cnt_q       <= '0;
      not_empty_o <= 1'b0;
      ovf_o       <= 1'b0;
    end else begin
      rd_q <= nxt_rd;
      if (wr_ok) wr_q <= wr_q + AW'(1);
      cnt_q       <= cnt_q + CW'(wr_ok) - CW'(pop_ok);
      not_empty_o <= (cnt_q + CW'(wr_ok) - CW'(pop_ok)) != '0;
      if (drop_o)         ovf_o <= 1'b1;
      else if (ovf_clr_i) ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/hit_capture_channel.sv
module hit_capture_channel #(
  parameter int TS_W    = 14,
  parameter int AMP_W   = 8,
  parameter int DEPTH   = 4,
  parameter int TMO     = 64,
  parameter int DC_W    = 8,
  parameter int CH_W    = 7,
  parameter int CHAN_ID = 5,
  parameter int SYNC_N  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_in,
  input  logic             amp_valid,
  input  logic [AMP_W-1:0] amp_data,
  input  logic             pop,
  input  logic             ovf_clear,
  output logic [TS_W-1:0]  time_now,
  output logic             not_empty,
  output logic [TS_W-1:0]  head_time,
  output logic [AMP_W-1:0] head_amp,
  output logic [CH_W-1:0]  head_chan,
  output logic             overflow,
  output logic [DC_W-1:0]  dead_count
);
  localparam int EW = TS_W + AMP_W;

  logic             rise_w, push_w, drop_w;
  logic [TS_W-1:0]  push_ts;
  logic [AMP_W-1:0] push_amp;
  logic [EW-1:0]    head_w;

  hcap_timer #(.TS_W(TS_W)) u_timer (
    .clk(clk), .rst(rst), .time_o(time_now)
  );

  hcap_trig_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .trig_i(trig_in), .rise_o(rise_w)
  );

  hcap_pair #(.TS_W(TS_W), .AMP_W(AMP_W), .TMO(TMO), .DC_W(DC_W)) u_pair (
    .clk(clk), .rst(rst), .rise_i(rise_w), .time_i(time_now),
    .amp_valid_i(amp_valid), .amp_i(amp_data),
    .push_o(push_w), .push_ts_o(push_ts), .push_amp_o(push_amp),
    .dead_o(dead_count)
  );

  hcap_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_i(push_w), .wr_data_i({push_ts, push_amp}),
    .pop_i(pop), .ovf_clr_i(ovf_clear), .not_empty_o(not_empty),
    .head_o(head_w), .drop_o(drop_w), .ovf_o(overflow)
  );

  assign head_time = head_w[EW-1:AMP_W];
  assign head_amp  = head_w[AMP_W-1:0];
  assign head_chan = CH_W'(CHAN_ID);
endmodule

// File: rtl/hcap_checker.sv
module hcap_checker #(
  parameter int TS_W = 14,
  parameter int DC_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic [TS_W-1:0] time_now,
  input logic            overflow,
  input logic            ovf_clear,
  input logic            not_empty,
  input logic            push_w,
  input logic            drop_w,
  input logic [DC_W-1:0] dead_count
);
  p_time_step_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> time_now == $past(time_now) + TS_W'(1));

  p_dead_mono_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> dead_count >= $past(dead_count));

  p_push_shows_r7: assert property (@(posedge clk) disable iff (rst)
    (push_w && !drop_w) |=> not_empty);

  p_empty_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!not_empty && !push_w) |=> !not_empty);

  p_drop_sets_r9: assert property (@(posedge clk) disable iff (rst)
    drop_w |=> overflow);

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (overflow && !ovf_clear) |=> overflow);

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (ovf_clear && !drop_w) |=> !overflow);
endmodule

bind hit_capture_channel hcap_checker #(.TS_W(TS_W), .DC_W(DC_W)) u_chk (
  .clk(clk), .rst(rst), .time_now(time_now), .overflow(overflow),
  .ovf_clear(ovf_clear), .not_empty(not_empty), .push_w(push_w),
  .drop_w(drop_w), .dead_count(dead_count)
);

// File: tb/hit_capture_channel_test.sv
module hit_capture_channel_test;
  localparam int TS_W = 14, AMP_W = 8, CH_W = 7, DC_W = 8, CHAN = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig_in = 1'b0, amp_valid = 1'b0, pop = 1'b0, ovf_clear = 1'b0;
  logic [AMP_W-1:0] amp_data = '0;
  logic [TS_W-1:0]  time_now, head_time;
  logic [AMP_W-1:0] head_amp;
  logic [CH_W-1:0]  head_chan;
  logic             not_empty, overflow;
  logic [DC_W-1:0]  dead_count;

  always #2.5 clk = ~clk;

  hit_capture_channel #(.CHAN_ID(CHAN)) uut (
    .clk(clk), .rst(rst), .trig_in(trig_in), .amp_valid(amp_valid),
    .amp_data(amp_data), .pop(pop), .ovf_clear(ovf_clear),
    .time_now(time_now), .not_empty(not_empty), .head_time(head_time),
    .head_amp(head_amp), .head_chan(head_chan), .overflow(overflow),
    .dead_count(dead_count)
  );

  int checks = 0, errors = 0, cycles = 0;

  // behavioural reference
  int m_cnt = 0, m_wait = 0, m_ts = 0, m_dead = 0;
  bit h0, h1, h2, m_pend, m_ovf;
  int q_ts[$];
  int q_amp[$];

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_cnt = 0; h0 = 0; h1 = 0; h2 = 0; m_pend = 0; m_wait = 0;
      m_dead = 0; m_ovf = 0; q_ts.delete(); q_amp.delete();
    end else begin
      bit rise, push, full, drop;
      rise = h1 && !h2;
      push = 0;
      if (m_pend) begin
        if (amp_valid) begin push = 1; m_pend = 0; end
        else if (m_wait == 63) m_pend = 0;
        else m_wait++;
        if (rise && m_dead < 255) m_dead++;
      end else if (rise) begin
        m_pend = 1; m_ts = m_cnt; m_wait = 0;
      end
      full = (q_ts.size() == 4);
      drop = push && full;
      if (pop && q_ts.size() > 0) begin
        void'(q_ts.pop_front()); void'(q_amp.pop_front());
      end
      if (push && !full) begin q_ts.push_back(m_ts); q_amp.push_back(int'(amp_data)); end
      if (drop) m_ovf = 1; else if (ovf_clear) m_ovf = 0;
      m_cnt = (m_cnt + 1) % 16384;
      h2 = h1; h1 = h0; h0 = trig_in;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && cycles > 0) begin
      chk(int'(time_now), m_cnt, "R1 time_now");
      chk(int'(not_empty), int'(q_ts.size() > 0), "R7 not_empty");
      if (q_ts.size() > 0) begin
        chk(int'(head_time), q_ts[0], "R3 head_time");
        chk(int'(head_amp), q_amp[0], "R3 head_amp");
      end
      chk(int'(overflow), int'(m_ovf), "R9 overflow");
      chk(int'(dead_count), m_dead, "R5 dead_count");
      chk(int'(head_chan), CHAN, "R11 head_chan");
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_trig(output int t_seen);
    trig_in = 1'b1;
    idle(2);
    t_seen = int'(time_now);
    trig_in = 1'b0;
    idle(2);
  endtask

  task automatic send_amp(input int v);
    amp_valid = 1'b1; amp_data = AMP_W'(v);
    idle(1);
    amp_valid = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1; idle(1); pop = 1'b0;
  endtask

  initial begin
    int t;
    idle(3);
    rst = 1'b0;
    chk(int'(not_empty), 0, "R12 empty after reset");
    chk(int'(overflow), 0, "R12 overflow after reset");
    chk(int'(dead_count), 0, "R12 dead after reset");
    chk(int'(time_now), 0, "R12 R1 time after reset");
    idle(4);
    // single hit
    pulse_trig(t);
    idle(5);
    send_amp(8'h5A);
    chk(int'(not_empty), 1, "R7 entry visible");
    chk(int'(head_time), t, "R2 captured time");
    chk(int'(head_amp), 8'h5A, "R3 amplitude");
    do_pop();
    chk(int'(not_empty), 0, "R8 pop empties");
    do_pop();
    chk(int'(not_empty), 0, "R8 pop on empty");
    // stray amplitude
    send_amp(8'h11);
    idle(1);
    chk(int'(not_empty), 0, "R6 stray amp ignored");
    // timeout
    pulse_trig(t);
    idle(70);
    send_amp(8'h22);
    idle(1);
    chk(int'(not_empty), 0, "R4 timeout discards");
    // late but in window
    pulse_trig(t);
    idle(55);
    send_amp(8'h33);
    chk(int'(head_time), t, "R3 late amp accepted");
    do_pop();
    // retrigger while armed
    pulse_trig(t);
    idle(3);
    trig_in = 1'b1; idle(3); trig_in = 1'b0; idle(3);
    send_amp(8'h44);
    chk(int'(dead_count), 1, "R5 retrigger counted");
    chk(int'(head_time), t, "R5 time kept");
    do_pop();
    idle(3);
    // fill beyond depth
    for (int k = 0; k < 5; k++) begin
      pulse_trig(t);
      idle(2);
      send_amp(16 * k + 1);
      idle(2);
    end
    chk(int'(overflow), 1, "R9 overflow set");
    idle(3);
    chk(int'(overflow), 1, "R9 overflow sticky");
    ovf_clear = 1'b1; idle(1); ovf_clear = 1'b0;
    chk(int'(overflow), 0, "R10 clear");
    chk(int'(head_amp), 1, "R7 order first");
    for (int k = 0; k < 4; k++) do_pop();
    chk(int'(not_empty), 0, "R8 drained");
    // wrap of the time counter
    while (time_now != 14'd16378) @(negedge clk);
    pulse_trig(t);
    idle(10);
    send_amp(8'h77);
    chk(int'(head_time), t, "R1 R2 stamp near wrap");
    do_pop();
    idle(5);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule